// File: doc/BRIEF.md
# Real-Time Clock with Periodic Interrupt

This block keeps time of day (seconds, minutes, hours) from a 32.768 kHz time base and offers a programmable periodic interrupt taken from the same divider chain. The time base arrives as `tick_i`, a one-cycle enable in the system clock domain, asserted once per 32.768 kHz period. A 15-bit divider chain counts these ticks. Each wrap of the chain is one second and advances the time counter. When an update completes, an update-ended flag is raised. For a short window before each update, a read-only flag in control register A warns software that the time fields are about to change.

Software reaches seven byte-wide registers through an index/data port. A write with `sel_i` low loads the index. A write with `sel_i` high writes the indexed register. `rdata_o` always shows the indexed register. A read strobe on the status register clears its flags. One level-sensitive interrupt line reports any flag whose enable is set.

Top module: `rtc_core`

## Requirements
- R1: After reset, register A reads 0x20, register B reads 0x02, register C reads 0x00, the three time registers read 0, and `irq_o` is low.
- R2: The divider chain runs only while A[6:4] = 010. Any other code holds the chain at zero. While it is held there are no time updates, no periodic flags, and A[7] reads 0.
- R3: A[3:0] = r selects the periodic rate. For r of 3 to 15, PF (C[6]) sets once every 2^(r-1) ticks. Codes 1 and 2 give the same period as codes 8 and 9. Code 0 never sets PF.
- R4: Each wrap of the divider advances seconds (index 0), with carries into minutes (index 1) and hours (index 2). Seconds and minutes roll over after 59; hours are stored 0..23 and roll over after 23. UF (C[4]) sets in the same cycle as the update. A time write in the update cycle takes precedence and suppresses that update.
- R5: A[7] is a read-only update-in-progress flag. It reads 1 for the last UIP_TICKS ticks before each update and returns to 0 when the update occurs. Writes to A[7] are ignored.
- R6: C[7] reads 1 whenever (PF and B[6]) or (UF and B[4]) holds, and `irq_o` equals C[7]. A read strobe (`rd_i` with `sel_i` high) while the index is 5 clears PF and UF, so `irq_o` falls after that cycle.
- R7: If a flag sets in the same cycle as a clearing read of C, the new flag survives the read.
- R8: When B[1] = 0 (12-hour mode), the hour register reads 1..12 in bits 3:0, with bit 7 set for PM; 0 h reads 0x0C and 13 h reads 0x81. Hour writes in this mode are interpreted in the same format. When B[1] = 1 (24-hour mode), the hour register reads and writes 0..23 in binary.
- R9: C[5] and C[3:0] read 0. Register D (index 6) reads 0x80. Writes to C and D have no effect.
- R10: The register indices are 0 seconds, 1 minutes, 2 hours, 3 A, 4 B, 5 C, 6 D. Writable B bits are 6 (periodic enable), 4 (update-ended enable) and 1 (24-hour mode); all other B bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz time-base enable, one cycle per tick |
| sel_i | input | 1 | 0 selects the index register, 1 selects the data register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; clears the status flags when the index is 5 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Contents of the indexed register |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The two functions that can land in the same cycle are a flag being raised (here the periodic event) and a clearing read of register C. The bench runs at rate code 3, first finds the phase of the periodic flag, then times the read strobe so that it meets the next set edge exactly. The flag must then still read 1 after the read. A read one cycle after a set must instead leave the flag at 0. A second coincidence, a time write landing on the update edge, is covered by an assertion: the counter advances only when no write is present.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_SEC    = 3'd0,
    IDX_MIN    = 3'd1,
    IDX_HOUR   = 3'd2,
    IDX_CTRL_A = 3'd3,
    IDX_CTRL_B = 3'd4,
    IDX_STAT_C = 3'd5,
    IDX_STAT_D = 3'd6
  } reg_idx_e;

  localparam logic [2:0] DIV_RUN = 3'b010;

  // codes 1 and 2 alias to 8 and 9
  function automatic logic [3:0] eff_rate(input logic [3:0] r);
    if (r == 4'd1)      return 4'd8;
    else if (r == 4'd2) return 4'd9;
    else                return r;
  endfunction

  function automatic logic [7:0] hr_to12(input logic [4:0] h);
    logic [4:0] b;
    if (h == 5'd0)       b = 5'd12;
    else if (h > 5'd12)  b = h - 5'd12;
    else                 b = h;
    return {(h >= 5'd12), 2'b00, b};
  endfunction

  function automatic logic [4:0] hr_from12(input logic [7:0] v);
    logic [4:0] b;
    b = (v[4:0] == 5'd12) ? 5'd0 : v[4:0];
    return b + (v[7] ? 5'd12 : 5'd0);
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_W     = 15,
  parameter int UIP_TICKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [3:0] rate_i,
  output logic       sec_pulse_o,
  output logic       per_pulse_o,
  output logic       uip_o
);
  import rtc_pkg::*;

  localparam logic [DIV_W-1:0] CNT_MAX   = '1;
  localparam logic [DIV_W-1:0] UIP_START = DIV_W'((2 ** DIV_W) - UIP_TICKS);

  logic [DIV_W-1:0] cnt_q;
  logic [3:0]       shamt;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    shamt = eff_rate(rate_i) - 4'd1;
    span  = ((DIV_W+1)'(1) << shamt) - 1'b1;
    mask  = span[DIV_W-1:0];
  end

  assign sec_pulse_o = run_i & tick_i & (cnt_q == CNT_MAX);
  assign per_pulse_o = run_i & tick_i & (rate_i != 4'd0) & ((cnt_q & mask) == mask);
  assign uip_o       = run_i & (cnt_q >= UIP_START);
endmodule

// File: rtl/rtc_time.sv
module rtc_time (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       ld_sec_i,
  input  logic       ld_min_i,
  input  logic       ld_hr_i,
  input  logic [5:0] ld_ms_i,
  input  logic [4:0] ld_hr_val_i,
  output logic [5:0] sec_o,
  output logic [5:0] min_o,
  output logic [4:0] hr_o
);
  logic ld_any;
  assign ld_any = ld_sec_i | ld_min_i | ld_hr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o <= '0;
      min_o <= '0;
      hr_o  <= '0;
    end else if (ld_any) begin
      if (ld_sec_i) sec_o <= ld_ms_i;
      if (ld_min_i) min_o <= ld_ms_i;
      if (ld_hr_i)  hr_o  <= ld_hr_val_i;
    end else if (step_i) begin
      if (sec_o >= 6'd59) begin
        sec_o <= '0;
        if (min_o >= 6'd59) begin
          min_o <= '0;
          hr_o  <= (hr_o >= 5'd23) ? 5'd0 : hr_o + 5'd1;
        end else begin
          min_o <= min_o + 6'd1;
        end
      end else begin
        sec_o <= sec_o + 6'd1;
      end
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DIV_W     = 15,
  parameter int UIP_TICKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  import rtc_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic [2:0]       div_q;
  logic [3:0]       rate_q;
  logic             pie_q, uie_q, h24_q;
  logic             pf_q, uf_q;
  logic             data_wr, rd_c, time_wr, run, upd, irqf;
  logic             sec_pulse, per_pulse, uip;
  logic [5:0]       sec_q, min_q;
  logic [4:0]       hr_q;
  logic             ld_sec, ld_min, ld_hr;

  assign data_wr = wr_i & sel_i;
  assign rd_c    = rd_i & sel_i & (idx_q == IDX_STAT_C);
  assign ld_sec  = data_wr & (idx_q == IDX_SEC);
  assign ld_min  = data_wr & (idx_q == IDX_MIN);
  assign ld_hr   = data_wr & (idx_q == IDX_HOUR);
  assign time_wr = ld_sec | ld_min | ld_hr;
  assign run     = (div_q == DIV_RUN);
  assign upd     = sec_pulse & ~time_wr;

  rtc_divider #(.DIV_W(DIV_W), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (run),
    .rate_i      (rate_q),
    .sec_pulse_o (sec_pulse),
    .per_pulse_o (per_pulse),
    .uip_o       (uip)
  );

  rtc_time u_time (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (sec_pulse),
    .ld_sec_i    (ld_sec),
    .ld_min_i    (ld_min),
    .ld_hr_i     (ld_hr),
    .ld_ms_i     (wdata_i[5:0]),
    .ld_hr_val_i (h24_q ? wdata_i[4:0] : hr_from12(wdata_i)),
    .sec_o       (sec_q),
    .min_o       (min_q),
    .hr_o        (hr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      div_q  <= DIV_RUN;
      rate_q <= '0;
      pie_q  <= 1'b0;
      uie_q  <= 1'b0;
      h24_q  <= 1'b1;
    end else if (wr_i && !sel_i) begin
      idx_q <= wdata_i[IDX_W-1:0];
    end else if (data_wr) begin
      if (idx_q == IDX_CTRL_A) begin
        div_q  <= wdata_i[6:4];
        rate_q <= wdata_i[3:0];
      end
      if (idx_q == IDX_CTRL_B) begin
        pie_q <= wdata_i[6];
        uie_q <= wdata_i[4];
        h24_q <= wdata_i[1];
      end
    end
  end

  // a new event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      pf_q <= (pf_q & ~rd_c) | per_pulse;
      uf_q <= (uf_q & ~rd_c) | upd;
    end
  end

  assign irqf  = (pf_q & pie_q) | (uf_q & uie_q);
  assign irq_o = irqf;

  always_comb begin
    case (idx_q)
      IDX_SEC:    rdata_o = {2'b00, sec_q};
      IDX_MIN:    rdata_o = {2'b00, min_q};
      IDX_HOUR:   rdata_o = h24_q ? {3'b000, hr_q} : hr_to12(hr_q);
      IDX_CTRL_A: rdata_o = {uip, div_q, rate_q};
      IDX_CTRL_B: rdata_o = {1'b0, pie_q, 1'b0, uie_q, 2'b00, h24_q, 1'b0};
      IDX_STAT_C: rdata_o = {irqf, pf_q, 1'b0, uf_q, 4'b0000};
      IDX_STAT_D: rdata_o = 8'h80;
      default:    rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       sec_pulse_i,
  input logic       upd_i,
  input logic       per_i,
  input logic       uip_i,
  input logic       rd_c_i,
  input logic [5:0] sec_i,
  input logic       pf_i,
  input logic       irq_i,
  input logic [2:0] idx_i,
  input logic [7:0] rdata_i
);
  p_no_pulse_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!sec_pulse_i && !per_i));

  p_sec_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (sec_i == (($past(sec_i) >= 6'd59) ? 6'd0 : 6'($past(sec_i) + 6'd1))));

  p_uip_at_update_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_i |-> uip_i);

  p_irq_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c_i && !per_i && !upd_i) |=> !irq_i);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_i && rd_c_i) |=> pf_i);

  p_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == 3'd5) |-> (rdata_i[3:0] == 4'd0 && !rdata_i[5]));
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run),
  .sec_pulse_i (sec_pulse),
  .upd_i       (upd),
  .per_i       (per_pulse),
  .uip_i       (uip),
  .rd_c_i      (rd_c),
  .sec_i       (sec_q),
  .pf_i        (pf_q),
  .irq_i       (irq_o),
  .idx_i       (idx_q),
  .rdata_i     (rdata_o)
);

// File: tb/rtc_core_tb_top.sv
`timescale 1ns/1ps
module rtc_core_tb_top;
  localparam int WD_CYCLES = 190000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       sel_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  rtc_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sel_i(sel_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start at a negedge and drive immediately
  task automatic sel_idx(input logic [7:0] i);
    sel_i = 1'b0; wr_i = 1'b1; wdata_i = i;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    sel_i = 1'b0; wr_i = 1'b1; wdata_i = i;
    @(negedge clk_i);
    sel_i = 1'b1; wdata_i = v;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic peek(input logic [7:0] i, output logic [7:0] v);
    sel_idx(i);
    v = rdata_o;
  endtask

  task automatic rd_clear();
    sel_i = 1'b1; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic wait_bit(input int b, input int maxc, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      if (rdata_o[b]) begin ok = 1'b1; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    peek(8'd3, v); check(v == 8'h20, "R1 regA", v, 8'h20);
    peek(8'd4, v); check(v == 8'h02, "R1 regB", v, 8'h02);
    peek(8'd5, v); check(v == 8'h00, "R1 regC", v, 8'h00);
    peek(8'd0, v); check(v == 8'h00, "R1 sec", v, 0);
    peek(8'd1, v); check(v == 8'h00, "R1 min", v, 0);
    peek(8'd2, v); check(v == 8'h00, "R1 hour", v, 0);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr_reg(8'd5, 8'hFF); v = rdata_o; check(v == 8'h00, "R9 regC write ignored", v, 0);
    wr_reg(8'd6, 8'h00); v = rdata_o; check(v == 8'h80, "R9 regD", v, 8'h80);
    wr_reg(8'd4, 8'hFF); v = rdata_o; check(v == 8'h52, "R10 regB writable bits", v, 8'h52);
    wr_reg(8'd3, 8'hA0); v = rdata_o; check(v == 8'h20, "R5 A bit7 read-only", v, 8'h20);
    wr_reg(8'd4, 8'h02);
  endtask

  task automatic t_12h();
    logic [7:0] v;
    wr_reg(8'd2, 8'd0);  wr_reg(8'd4, 8'h00);
    peek(8'd2, v); check(v == 8'h0C, "R8 midnight", v, 8'h0C);
    wr_reg(8'd4, 8'h02); wr_reg(8'd2, 8'd13); wr_reg(8'd4, 8'h00);
    peek(8'd2, v); check(v == 8'h81, "R8 13h", v, 8'h81);
    wr_reg(8'd4, 8'h02); wr_reg(8'd2, 8'd12); wr_reg(8'd4, 8'h00);
    peek(8'd2, v); check(v == 8'h8C, "R8 noon", v, 8'h8C);
    wr_reg(8'd2, 8'h87); wr_reg(8'd4, 8'h02);
    peek(8'd2, v); check(v == 8'h13, "R8 12h write 7PM", v, 8'h13);
    wr_reg(8'd4, 8'h00); wr_reg(8'd2, 8'h0C); wr_reg(8'd4, 8'h02);
    peek(8'd2, v); check(v == 8'h00, "R8 12h write 12AM", v, 0);
  endtask

  task automatic t_period(input logic [3:0] rate, input longint exp);
    logic ok;
    longint t1;
    wr_reg(8'd3, {4'h2, rate});
    wr_reg(8'd4, 8'h42);
    sel_idx(8'd5);
    rd_clear();
    wait_bit(6, int'(exp) * 2 + 20, ok);
    check(ok, "R3 first periodic flag", ok, 1);
    check(irq_o == 1'b1, "R6 irq with PIE", irq_o, 1);
    t1 = cyc;
    rd_clear();
    check(irq_o == 1'b0, "R6 irq cleared by read", irq_o, 0);
    wait_bit(6, int'(exp) * 2 + 20, ok);
    check(ok && (cyc - t1 == exp), "R3 periodic interval", cyc - t1, exp);
  endtask

  task automatic t_rate_off();
    wr_reg(8'd3, 8'h20);
    sel_idx(8'd5);
    rd_clear();
    repeat (300) @(negedge clk_i);
    check(rdata_o == 8'h00, "R3 rate 0 no flag", rdata_o, 0);
  endtask

  task automatic t_held();
    logic [7:0] s0, v;
    peek(8'd0, s0);
    wr_reg(8'd3, 8'h03);
    sel_idx(8'd5);
    rd_clear();
    repeat (200) @(negedge clk_i);
    check(rdata_o == 8'h00, "R2 held no flags", rdata_o, 0);
    peek(8'd3, v); check(v == 8'h03, "R2 held uip low", v, 8'h03);
    peek(8'd0, v); check(v == s0, "R2 held time frozen", v, s0);
  endtask

  task automatic t_same_cycle();
    logic ok;
    wr_reg(8'd3, 8'h23);
    wr_reg(8'd4, 8'h42);
    sel_idx(8'd5);
    rd_clear();
    wait_bit(6, 40, ok);
    repeat (3) @(negedge clk_i);
    rd_clear();
    check(rdata_o[6] == 1'b1, "R7 flag set with read survives", rdata_o[6], 1);
    rd_clear();
    check(rdata_o[6] == 1'b0, "R6 read clears flag", rdata_o[6], 0);
    wr_reg(8'd3, 8'h20);
    sel_idx(8'd5);
    rd_clear();
  endtask

  task automatic t_time();
    logic [7:0] v;
    logic a7;
    longint t_uip, t_irq;
    wr_reg(8'd3, 8'h00);
    wr_reg(8'd0, 8'd58); wr_reg(8'd1, 8'd59); wr_reg(8'd2, 8'd23);
    wr_reg(8'd4, 8'h12);
    sel_idx(8'd5); rd_clear();
    wr_reg(8'd3, 8'h20);
    t_uip = -1; t_irq = -1; a7 = 1'b1;
    for (int i = 0; i < 33000; i++) begin
      if (rdata_o[7] && t_uip < 0) t_uip = cyc;
      if (irq_o) begin t_irq = cyc; a7 = rdata_o[7]; break; end
      @(negedge clk_i);
    end
    check(t_irq >= 0 && t_uip >= 0 && (t_irq - t_uip == 8), "R5 uip window", t_irq - t_uip, 8);
    check(a7 == 1'b0, "R5 uip clears at update", a7, 0);
    peek(8'd0, v); check(v == 8'd59, "R4 sec step", v, 59);
    peek(8'd1, v); check(v == 8'd59, "R4 min held", v, 59);
    peek(8'd5, v); check(v == 8'h90, "R4 UF and IRQF", v, 8'h90);
    rd_clear();
    check(irq_o == 1'b0, "R6 UF cleared", irq_o, 0);
    t_irq = -1;
    for (int i = 0; i < 33000; i++) begin
      if (irq_o) begin t_irq = cyc; break; end
      @(negedge clk_i);
    end
    check(t_irq >= 0, "R4 second update", t_irq, 1);
    peek(8'd0, v); check(v == 8'd0, "R4 sec rollover", v, 0);
    peek(8'd1, v); check(v == 8'd0, "R4 min rollover", v, 0);
    peek(8'd2, v); check(v == 8'd0, "R4 hour rollover", v, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reserved();
    t_12h();
    t_period(4'd3, 4);
    t_period(4'd6, 32);
    t_period(4'd1, 128);
    t_period(4'd8, 128);
    t_period(4'd2, 256);
    t_period(4'd15, 16384);
    t_rate_off();
    t_held();
    t_same_cycle();
    t_time();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule